// File: doc/BRIEF.md
# Stipple pixel expansion engine

The engine turns one 32-bit stipple word into a run of up to 32 byte-wide pixel writes into an 8-bit frame buffer. It sits behind a write-only 32-bit register port. Two kinds of write reach it, and bit 2 of the bus address tells them apart. The first kind latches a colour. The second kind supplies a stipple mask, and its bus address also carries the pixel address where the run begins.

Once a mask write is accepted, the engine steps through the 32 pixel slots, one slot per clock cycle. The leftmost pixel takes the most significant mask bit. A slot whose bit is set writes the low byte of the latched colour. A slot whose bit is clear writes nothing.

When deep-colour mode is selected at the start of a run, each written pixel also writes a 32-bit word into a second plane, with the colour stored byte-reversed. While a run is in progress the bus port holds off further writes. When the run finishes, the engine reports the 32-pixel span it covered as dirty.

Top module: `stip_expander`

## Requirements
- R1: A write accepted with bus address bit 2 clear stores the 32-bit data as the latched colour. It starts no run and causes no pixel write.
- R2: A write accepted with bus address bit 2 set starts a run. The base pixel address is bus address bits [PIX_AW+2:3].
- R3: In the k-th cycle after the accepting edge (k = 0..31), the frame-buffer port addresses pixel base+k, modulo 2^PIX_AW. Mask bit 31-k governs that slot, so bit 31 maps to base+0 and bit 0 maps to base+31.
- R4: A slot whose mask bit is set asserts fb_we_o for that one cycle, with fb_data_o equal to bits [7:0] of the latched colour. A slot whose mask bit is clear leaves fb_we_o low, so that pixel keeps its value.
- R5: If deep_i is high on the accepting edge, deep_we_o follows fb_we_o for the whole run and deep_data_o carries the colour byte-reversed: colour bits [7:0] appear on bits [31:24], and colour bits [31:24] appear on bits [7:0]. If deep_i is low, deep_we_o stays low. Changes to deep_i during a run have no effect.
- R6: busy_o is high for exactly 32 cycles per run, even when the mask is all zeros. bus_ready_o is low while busy_o is high. Writes presented during a run are ignored: they change neither the colour nor the run.
- R7: In the cycle in which busy_o falls, dirty_valid_o pulses high for one cycle and dirty_base_o equals the run's base address. The dirty span is 32 pixels from that base.
- R8: bus_rdata_o always reads zero.
- R9: After reset the engine is idle: busy_o is low, bus_ready_o is high, no write enable is active, and the latched colour is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| deep_i | input | 1 | Deep-colour mode select, sampled when a run starts |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | PIX_AW+3 | Bus byte address |
| bus_wdata_i | input | 32 | Bus write data (colour or mask) |
| bus_ready_o | output | 1 | High when a write can be accepted |
| bus_rdata_o | output | 32 | Read data, always zero |
| busy_o | output | 1 | A run is in progress |
| fb_we_o | output | 1 | Frame-buffer byte write enable |
| fb_addr_o | output | PIX_AW | Frame-buffer pixel address |
| fb_data_o | output | 8 | Frame-buffer pixel byte |
| deep_we_o | output | 1 | Deep-plane write enable |
| deep_data_o | output | 32 | Deep-plane word, byte-reversed colour |
| dirty_valid_o | output | 1 | One-cycle pulse marking the finished span |
| dirty_base_o | output | PIX_AW | First pixel of the dirty span |

## Verification
The bench builds the engine with its default pixel address width of 20 bits, which is the full range the bus address can reach. With that width, runs can start just below the top of the pixel space, so the directed cases can reach the point where the slot address wraps back to zero. The mask stays at 32 bits, which places the all-zero, all-one and end-bit masks among the cases. It also lets the 32-cycle busy window be counted against the bus writes the bench injects during a run.

// File: rtl/stip_pkg.sv
package stip_pkg;
  localparam int unsigned MASK_W  = 32;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned COLOR_W = 32;
  localparam int unsigned SLOT_W  = $clog2(MASK_W);

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic              deep;
  } stip_job_t;
endpackage

// File: rtl/stip_cmd_decode.sv
module stip_cmd_decode
  import stip_pkg::*;
#(
  parameter int unsigned PIX_AW = 20,
  localparam int unsigned BUS_AW = PIX_AW + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               ready_i,
  input  logic [BUS_AW-1:0]  addr_i,
  input  logic [COLOR_W-1:0] wdata_i,
  input  logic               deep_i,
  output logic [COLOR_W-1:0] colour_o,
  output logic               start_o,
  output stip_job_t          job_o,
  output logic [PIX_AW-1:0]  base_o
);
  logic               accept;
  logic [COLOR_W-1:0] colour_q;
  logic               unused_lo;

  assign unused_lo = ^addr_i[1:0];
  assign accept    = wr_i & ready_i;
  assign start_o   = accept & addr_i[2];
  assign base_o    = addr_i[BUS_AW-1:3];
  assign job_o     = '{mask: wdata_i[MASK_W-1:0], deep: deep_i};
  assign colour_o  = colour_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  colour_q <= '0;
    else if (accept && !addr_i[2]) colour_q <= wdata_i;
  end
endmodule

// File: rtl/stip_sweep.sv
module stip_sweep
  import stip_pkg::*;
#(
  parameter int unsigned PIX_AW = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  stip_job_t         job_i,
  input  logic [PIX_AW-1:0] base_i,
  output logic              busy_o,
  output logic              slot_we_o,
  output logic              slot_deep_o,
  output logic [PIX_AW-1:0] slot_addr_o,
  output logic              done_o,
  output logic [PIX_AW-1:0] done_base_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(MASK_W - 1);

  logic              busy_q, deep_q, done_q;
  logic [MASK_W-1:0] mask_q;
  logic [PIX_AW-1:0] base_q;
  logic [SLOT_W-1:0] slot_q;
  logic              last_slot;

  assign last_slot = busy_q && (slot_q == LAST_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      deep_q <= 1'b0;
      done_q <= 1'b0;
      mask_q <= '0;
      base_q <= '0;
      slot_q <= '0;
    end else begin
      done_q <= last_slot;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        mask_q <= job_i.mask;
        deep_q <= job_i.deep;
        base_q <= base_i;
        slot_q <= '0;
      end else if (busy_q) begin
        mask_q <= mask_q << 1;
        slot_q <= slot_q + 1'b1;
        if (last_slot) busy_q <= 1'b0;
      end
    end
  end

  // MSB of the shifting mask governs the current (leftmost remaining) pixel
  assign busy_o      = busy_q;
  assign slot_we_o   = busy_q & mask_q[MASK_W-1];
  assign slot_deep_o = deep_q;
  assign slot_addr_o = base_q + PIX_AW'(slot_q);
  assign done_o      = done_q;
  assign done_base_o = base_q;
endmodule

// File: rtl/stip_pixel_fmt.sv
module stip_pixel_fmt
  import stip_pkg::*;
(
  input  logic [COLOR_W-1:0] colour_i,
  output logic [PIX_W-1:0]   pix_o,
  output logic [COLOR_W-1:0] deep_o
);
  localparam int unsigned NBYTES = COLOR_W / 8;

  assign pix_o = colour_i[PIX_W-1:0];

  // big-endian store: byte lanes reversed
  for (genvar i = 0; i < NBYTES; i++) begin : g_swap
    assign deep_o[8*i +: 8] = colour_i[8*(NBYTES-1-i) +: 8];
  end
endmodule

// File: rtl/stip_expander.sv
module stip_expander
  import stip_pkg::*;
#(
  parameter int unsigned PIX_AW = 20,
  localparam int unsigned BUS_AW = PIX_AW + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               deep_i,
  input  logic               bus_wr_i,
  input  logic [BUS_AW-1:0]  bus_addr_i,
  input  logic [COLOR_W-1:0] bus_wdata_i,
  output logic               bus_ready_o,
  output logic [COLOR_W-1:0] bus_rdata_o,
  output logic               busy_o,
  output logic               fb_we_o,
  output logic [PIX_AW-1:0]  fb_addr_o,
  output logic [PIX_W-1:0]   fb_data_o,
  output logic               deep_we_o,
  output logic [COLOR_W-1:0] deep_data_o,
  output logic               dirty_valid_o,
  output logic [PIX_AW-1:0]  dirty_base_o
);
  logic [COLOR_W-1:0] colour;
  logic               start, busy, slot_we, slot_deep;
  stip_job_t          job;
  logic [PIX_AW-1:0]  base;

  assign bus_ready_o = ~busy;
  assign bus_rdata_o = '0;
  assign busy_o      = busy;

  stip_cmd_decode #(.PIX_AW(PIX_AW)) u_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr_i),
    .ready_i  (bus_ready_o),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .deep_i   (deep_i),
    .colour_o (colour),
    .start_o  (start),
    .job_o    (job),
    .base_o   (base)
  );

  stip_sweep #(.PIX_AW(PIX_AW)) u_sweep (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .job_i       (job),
    .base_i      (base),
    .busy_o      (busy),
    .slot_we_o   (slot_we),
    .slot_deep_o (slot_deep),
    .slot_addr_o (fb_addr_o),
    .done_o      (dirty_valid_o),
    .done_base_o (dirty_base_o)
  );

  stip_pixel_fmt u_fmt (
    .colour_i (colour),
    .pix_o    (fb_data_o),
    .deep_o   (deep_data_o)
  );

  assign fb_we_o   = slot_we;
  assign deep_we_o = slot_we & slot_deep;
endmodule

// File: rtl/stip_expander_chk.sv
module stip_expander_chk
  import stip_pkg::*;
#(
  parameter int unsigned PIX_AW = 20,
  localparam int unsigned BUS_AW = PIX_AW + 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               deep_i,
  input logic               bus_wr_i,
  input logic [BUS_AW-1:0]  bus_addr_i,
  input logic [COLOR_W-1:0] bus_wdata_i,
  input logic               bus_ready_o,
  input logic [COLOR_W-1:0] bus_rdata_o,
  input logic               busy_o,
  input logic               fb_we_o,
  input logic [PIX_AW-1:0]  fb_addr_o,
  input logic [PIX_W-1:0]   fb_data_o,
  input logic               deep_we_o,
  input logic [COLOR_W-1:0] deep_data_o,
  input logic               dirty_valid_o,
  input logic [PIX_AW-1:0]  dirty_base_o
);
  logic [SLOT_W+1:0] run_q;
  logic              unused_chk;

  assign unused_chk = ^{deep_i, bus_wdata_i, bus_rdata_o, deep_data_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (!busy_o) run_q <= '0;
    else              run_q <= run_q + 1'b1;
  end

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_ready_o && bus_addr_i[2]) |=>
      (busy_o && fb_addr_o == $past(bus_addr_i[BUS_AW-1:3])));

  assert_colour_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_ready_o && !bus_addr_i[2]) |=> !busy_o);

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> fb_addr_o == PIX_AW'($past(fb_addr_o) + 1'b1));

  assert_we_in_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_we_o |-> busy_o);

  assert_deep_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_we_o |-> fb_we_o);

  assert_busy_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == (SLOT_W+2)'(MASK_W));

  assert_colour_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(fb_data_o));

  assert_dirty_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> dirty_valid_o);

  assert_dirty_base_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_valid_o |-> $past(fb_addr_o) == PIX_AW'(dirty_base_o + PIX_AW'(MASK_W - 1)));
endmodule

bind stip_expander stip_expander_chk #(.PIX_AW(PIX_AW)) u_chk (.*);

// File: tb/stip_expander_bench.sv
`timescale 1ns/1ps
module stip_expander_bench;
  localparam int unsigned PIX_AW = 20;
  localparam int unsigned BUS_AW = PIX_AW + 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              deep_i = 1'b0;
  logic              bus_wr_i = 1'b0;
  logic [BUS_AW-1:0] bus_addr_i = '0;
  logic [31:0]       bus_wdata_i = '0;
  logic              bus_ready_o, busy_o, fb_we_o, deep_we_o, dirty_valid_o;
  logic [31:0]       bus_rdata_o, deep_data_o;
  logic [PIX_AW-1:0] fb_addr_o, dirty_base_o;
  logic [7:0]        fb_data_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] colour_m = '0;

  always #4 clk = ~clk;

  stip_expander #(.PIX_AW(PIX_AW)) u_stip_expander (
    .clk_i(clk), .rst_ni(rst_ni), .deep_i(deep_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_ready_o(bus_ready_o), .bus_rdata_o(bus_rdata_o), .busy_o(busy_o),
    .fb_we_o(fb_we_o), .fb_addr_o(fb_addr_o), .fb_data_o(fb_data_o),
    .deep_we_o(deep_we_o), .deep_data_o(deep_data_o),
    .dirty_valid_o(dirty_valid_o), .dirty_base_o(dirty_base_o)
  );

  function automatic logic [31:0] swap_bytes(input logic [31:0] c);
    return {c[7:0], c[15:8], c[23:16], c[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // R1: colour write, bit 2 clear
  task automatic write_colour(input logic [31:0] c, input logic [PIX_AW-1:0] a);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = {a, 3'b000}; bus_wdata_i = c;
    @(negedge clk);
    bus_wr_i = 1'b0;
    colour_m = c;
    chk(!busy_o && !fb_we_o, "R1", {30'd0, busy_o, fb_we_o}, 32'd0);
  endtask

  task automatic run_expand(input logic [PIX_AW-1:0] base, input logic [31:0] mask,
                            input bit deep, input bit inject);
    logic exp_we;
    logic [PIX_AW-1:0] exp_addr;
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = {base, 3'b100}; bus_wdata_i = mask; deep_i = deep;
    @(negedge clk);
    bus_wr_i = 1'b0;
    for (int k = 0; k < 32; k++) begin
      if (k > 0) @(negedge clk);
      if (inject && k == 5) begin
        bus_wr_i = 1'b1; bus_addr_i = {~base, 1'b0, 2'b00};
        bus_wdata_i = ~colour_m; deep_i = ~deep;
      end
      if (inject && k == 6) begin
        bus_wr_i = 1'b0; deep_i = deep;
      end
      exp_we = mask[31-k];
      exp_addr = base + PIX_AW'(k);
      chk(busy_o && !bus_ready_o, "R6", {30'd0, busy_o, bus_ready_o}, 32'd2);
      chk(fb_we_o == exp_we, "R4", {31'd0, fb_we_o}, {31'd0, exp_we});
      chk(fb_addr_o == exp_addr, "R3", 32'(fb_addr_o), 32'(exp_addr));
      if (exp_we) chk(fb_data_o == colour_m[7:0], "R4", 32'(fb_data_o), 32'(colour_m[7:0]));
      chk(deep_we_o == (exp_we & deep), "R5", {31'd0, deep_we_o}, {31'd0, exp_we & deep});
      if (exp_we && deep)
        chk(deep_data_o == swap_bytes(colour_m), "R5", deep_data_o, swap_bytes(colour_m));
      chk(bus_rdata_o == 32'd0, "R8", bus_rdata_o, 32'd0);
    end
    @(negedge clk);
    chk(!busy_o && bus_ready_o, "R6", {30'd0, busy_o, bus_ready_o}, 32'd1);
    chk(dirty_valid_o, "R7", {31'd0, dirty_valid_o}, 32'd1);
    chk(dirty_base_o == base, "R7", 32'(dirty_base_o), 32'(base));
    @(negedge clk);
    chk(!dirty_valid_o && !busy_o, "R7", {30'd0, dirty_valid_o, busy_o}, 32'd0);
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd2718));
    #3;
    chk(!busy_o && bus_ready_o && !fb_we_o && !deep_we_o && !dirty_valid_o,
        "R9", {27'd0, busy_o, bus_ready_o, fb_we_o, deep_we_o, dirty_valid_o}, 32'h8);
    chk(bus_rdata_o == 32'd0, "R8", bus_rdata_o, 32'd0);
    #20 rst_ni = 1'b1;
    // R9: colour resets to zero; expand all ones with no colour write
    run_expand(20'h00010, 32'hFFFF_FFFF, 1'b1, 1'b0);
    // directed corners
    write_colour(32'hA1B2_C3D4, 20'h00055);
    run_expand(20'h00000, 32'h8000_0001, 1'b0, 1'b0);
    run_expand(20'hFFFF0, 32'hFFFF_FFFF, 1'b1, 1'b0);        // R3 wrap
    run_expand(20'h12345, 32'h0000_0000, 1'b1, 1'b0);        // R6 empty mask
    run_expand(20'h00400, 32'h5A5A_F00F, 1'b1, 1'b1);        // R6 ignored writes
    run_expand(20'h00420, 32'hFFFF_FFFF, 1'b0, 1'b0);        // colour unchanged
    for (int i = 0; i < 50; i++) begin
      write_colour($urandom, PIX_AW'($urandom));
      run_expand(PIX_AW'($urandom), $urandom, 1'($urandom), (i % 7) == 3);
    end
    report();
  end
endmodule